// File: doc/BRIEF.md
# Sign-Correlation Weight Update Array

This block holds the cross-coupling weights of a two-channel feedback source separator and adapts them from one frame of separated outputs. Each of its 2L+1 update elements owns one tap index p, from −L to L, and keeps a signed running cost u_p. A frame of N output pairs (y1, y2) is loaded through a write port while the block is idle. A start pulse then launches an update pass of 2N update cycles, which is twice the frame's sample count. In every cycle the elements whose index has the same parity as the cycle number apply a decorrelation step. That step is the sign of a delayed y1 sample times a differently delayed y2 sample, scaled by a power-of-two learning rate and subtracted from the cost.

Costs are not cleared between passes, so successive frames keep refining the same weights. All costs leave the block together on one flat output bus, and the weight-reload logic reads them there. A controller with three states sequences the pass. `IDLE` waits and accepts sample writes, and moves to `RUN` on start. `RUN` steps the update time t from 0 to 2N−1 and moves to `DONE` after the last step. `DONE` lasts exactly one cycle and then returns to `IDLE`.

Top module: `sca_update_array`

## Requirements
- R1: While reset is low and in the first cycle after reset, every cost is zero, and `busy` and `done` are low.
- R2: A `start` sampled in `IDLE` makes `busy` high from the next cycle, for 2N update cycles in `RUN` followed by one `DONE` cycle. `done` is high only in that `DONE` cycle, and the block is idle after it.
- R3: In update cycle t (0..2N−1) only the elements whose p has the same parity as t change. Elements of the other parity hold their cost.
- R4: An active element p forms a = y1[floor((t−p−L)/2)] and b = y2[floor((t+p−L)/2)] and sets u_p ← u_p − sign(a)·(b >>> `eta_shift`). The bracketed index is the write address of the sample.
- R5: sign(a) is +1 for a > 0, −1 for a < 0 and 0 for a = 0. A zero a leaves the cost unchanged whatever b is.
- R6: The learning rate is an arithmetic right shift of b by `eta_shift` (0..15), applied before the sign. A negative b therefore rounds toward minus infinity.
- R7: A y1 or y2 index outside 0..N−1 supplies a zero sample, and so contributes nothing.
- R8: A cost clamps at the largest and smallest value of its AW-bit two's complement range and does not wrap.
- R9: While `busy` is high, sample writes and `start` are ignored. The stored frame and the pass length are unaffected.
- R10: In `IDLE`, `wr_en` stores `wr_y1` and `wr_y2` at frame index `wr_addr`, and that pair is used by the next pass.
- R11: Costs persist from one pass to the next. Element p occupies bits [(p+L)·AW +: AW] of `cost_all`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update clock (twice the sample rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one output pair into the frame store |
| wr_addr | input | $clog2(N) | Frame index of the written pair |
| wr_y1 | input | DW | Signed y1 sample |
| wr_y2 | input | DW | Signed y2 sample |
| start | input | 1 | Launch an update pass |
| eta_shift | input | SW | Learning-rate right shift |
| busy | output | 1 | Pass in progress (`RUN` or `DONE`) |
| done | output | 1 | One-cycle pulse after the last update |
| cost_all | output | (2L+1)·AW | All element costs, element p at slot p+L |

## Verification
Two things can fall in the same cycle. A sample write and a start can arrive together with an update step, and an accumulator can reach its clamp in the very step where an opposite-parity element is held. The bench drives writes with new values and extra start pulses through every cycle of a pass. It judges the result by checking that the costs of that pass and of the next one still follow the frame as it was before the pass. Saturation is provoked by repeating passes on full-scale samples with zero shift, in both directions. The reference model is compared on all costs, `busy` and `done` every clock, so a step that lands on a clamp and a held element are both judged in the cycle they occur.

// File: rtl/sca_pkg.sv
package sca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sca_state_e;
endpackage

// File: rtl/sca_ctrl.sv
module sca_ctrl
    import sca_pkg::*;
#(
    parameter int N  = 16,
    localparam int TW = $clog2(2 * N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          idle,
    output logic          run,
    output logic          busy,
    output logic          done,
    output logic [TW-1:0] t
);
    localparam logic [TW-1:0] T_LAST = TW'(2 * N - 1);

    sca_state_e state, state_nx;
    logic [TW-1:0] t_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            t     <= '0;
        end else begin
            state <= state_nx;
            t     <= t_nx;
        end
    end

    // transitions: IDLE->RUN on start, RUN->DONE at last step, DONE->IDLE
    always_comb begin
        state_nx = state;
        t_nx     = t;
        unique case (state)
            ST_IDLE: begin
                t_nx = '0;
                if (start) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (t == T_LAST) begin
                    state_nx = ST_DONE;
                    t_nx     = '0;
                end else begin
                    t_nx = t + 1'b1;
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle = 1'b0;
        run  = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: idle = 1'b1;
            ST_RUN:  run  = 1'b1;
            ST_DONE: done = 1'b1;
            default: idle = 1'b1;
        endcase
        busy = !idle;
    end
endmodule

// File: rtl/sca_store.sv
module sca_store #(
    parameter int N  = 16,
    parameter int DW = 12,
    localparam int AB = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 wr_en,
    input  logic [AB-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_y1,
    input  logic signed [DW-1:0] wr_y2,
    output logic signed [DW-1:0] y1_mem [N],
    output logic signed [DW-1:0] y2_mem [N]
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                y1_mem[i] <= '0;
                y2_mem[i] <= '0;
            end
        end else if (accept && wr_en && (int'(wr_addr) < N)) begin
            y1_mem[wr_addr] <= wr_y1;
            y2_mem[wr_addr] <= wr_y2;
        end
    end
endmodule

// File: rtl/sca_elem.sv
module sca_elem #(
    parameter int DW = 12,
    parameter int AW = 16,
    parameter int SW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic [SW-1:0]        shamt,
    output logic signed [AW-1:0] cost
);
    localparam logic signed [AW:0] MAXV = {2'b00, {(AW-1){1'b1}}};
    localparam logic signed [AW:0] MINV = {2'b11, {(AW-1){1'b0}}};

    logic signed [DW-1:0] scaled;
    logic signed [AW:0]   ext, delta, sum, sat;

    always_comb begin
        scaled = b >>> shamt;
        ext    = scaled;
        if (a > 0)      delta = -ext;
        else if (a < 0) delta = ext;
        else            delta = '0;
        sum = {cost[AW-1], cost} + delta;
        if (sum > MAXV)      sat = MAXV;
        else if (sum < MINV) sat = MINV;
        else                 sat = sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  cost <= '0;
        else if (en) cost <= sat[AW-1:0];
    end
endmodule

// File: rtl/sca_update_array.sv
module sca_update_array
    import sca_pkg::*;
#(
    parameter int L  = 4,
    parameter int N  = 16,
    parameter int DW = 12,
    parameter int AW = 16,
    parameter int SW = 4,
    localparam int NE = 2 * L + 1,
    localparam int AB = $clog2(N),
    localparam int TW = $clog2(2 * N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AB-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_y1,
    input  logic signed [DW-1:0] wr_y2,
    input  logic                 start,
    input  logic [SW-1:0]        eta_shift,
    output logic                 busy,
    output logic                 done,
    output logic [NE*AW-1:0]     cost_all
);
    logic          idle, run;
    logic [TW-1:0] t;
    logic signed [DW-1:0] y1_mem [N];
    logic signed [DW-1:0] y2_mem [N];

    sca_ctrl #(.N(N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .idle(idle), .run(run), .busy(busy), .done(done), .t(t)
    );

    sca_store #(.N(N), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .accept(idle), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_y1(wr_y1), .wr_y2(wr_y2),
        .y1_mem(y1_mem), .y2_mem(y2_mem)
    );

    for (genvar k = 0; k < NE; k++) begin : g_elem
        localparam int  P    = k - L;
        localparam bit  PODD = (P % 2) != 0;
        int ia, ib;
        logic signed [DW-1:0] sa, sb;
        logic en;
        logic signed [AW-1:0] c;

        always_comb begin
            ia = (int'(t) - P - L) >>> 1;
            ib = (int'(t) + P - L) >>> 1;
            sa = (ia >= 0 && ia < N) ? y1_mem[ia[AB-1:0]] : '0;
            sb = (ib >= 0 && ib < N) ? y2_mem[ib[AB-1:0]] : '0;
            en = run && (t[0] == PODD);
        end

        sca_elem #(.DW(DW), .AW(AW), .SW(SW)) u_elem (
            .clk(clk), .rst_n(rst_n), .en(en), .a(sa), .b(sb),
            .shamt(eta_shift), .cost(c)
        );

        assign cost_all[k*AW +: AW] = c;
    end
endmodule

// File: rtl/sca_update_array_chk.sv
module sca_update_array_chk #(
    parameter int L  = 4,
    parameter int AW = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     busy,
    input logic                     done,
    input logic [(2*L+1)*AW-1:0]    cost_all
);
    AST_START_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done)); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2

    AST_IDLE_COST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(cost_all)); // R11
endmodule

bind sca_update_array sca_update_array_chk #(.L(L), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cost_all(cost_all)
);

// File: tb/tb_sca_update_array.sv
module tb_sca_update_array;
    localparam int L  = 4;
    localparam int N  = 16;
    localparam int DW = 12;
    localparam int AW = 16;
    localparam int SW = 4;
    localparam int NE = 2 * L + 1;
    localparam int AB = $clog2(N);

    logic clk = 0, rst_n = 0, wr_en = 0, start = 0;
    logic [AB-1:0] wr_addr = '0;
    logic signed [DW-1:0] wr_y1 = '0, wr_y2 = '0;
    logic [SW-1:0] eta_shift = '0;
    logic busy, done;
    logic [NE*AW-1:0] cost_all;

    int checks = 0, errors = 0;
    string phase = "R1";

    sca_update_array #(.L(L), .N(N), .DW(DW), .AW(AW), .SW(SW)) dut (.*);

    always #10 clk = ~clk;

    // behavioural reference model
    int m_state = 0, m_t = 0;
    int m_y1 [N], m_y2 [N], m_u [NE];
    int cmax = (1 <<< (AW - 1)) - 1;
    int cmin = -(1 <<< (AW - 1));

    function automatic int fl2(int x);
        return (x < 0) ? -((-x + 1) / 2) : x / 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_t = 0;
            for (int i = 0; i < N; i++) begin m_y1[i] = 0; m_y2[i] = 0; end
            for (int k = 0; k < NE; k++) m_u[k] = 0;
        end else if (m_state == 0) begin
            if (wr_en) begin m_y1[wr_addr] = wr_y1; m_y2[wr_addr] = wr_y2; end
            if (start) begin m_state = 1; m_t = 0; end
        end else if (m_state == 1) begin
            for (int k = 0; k < NE; k++) begin
                int p, i1, i2, a, b, d, s;
                p = k - L;
                if (((m_t - p) % 2) == 0) begin
                    i1 = fl2(m_t - p - L);
                    i2 = fl2(m_t + p - L);
                    a = (i1 >= 0 && i1 < N) ? m_y1[i1] : 0;
                    b = (i2 >= 0 && i2 < N) ? m_y2[i2] : 0;
                    d = b >>> int'(eta_shift);
                    s = (a > 0) ? m_u[k] - d : (a < 0) ? m_u[k] + d : m_u[k];
                    m_u[k] = (s > cmax) ? cmax : (s < cmin) ? cmin : s;
                end
            end
            if (m_t == 2 * N - 1) m_state = 2; else m_t++;
        end else begin
            m_state = 0;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int bad;
            bad = -1;
            checks++;
            for (int k = 0; k < NE; k++)
                if (int'($signed(cost_all[k*AW +: AW])) != m_u[k] && bad < 0) bad = k;
            if (bad >= 0) begin
                errors++;
                $display("FAIL %s cost p=%0d actual=%0d expected=%0d", phase, bad - L,
                         $signed(cost_all[bad*AW +: AW]), m_u[bad]);
            end
            checks++;
            if (busy != (m_state != 0) || done != (m_state == 2)) begin
                errors++;
                $display("FAIL R2 busy/done actual=%0b/%0b expected=%0b/%0b", busy, done,
                         m_state != 0, m_state == 2);
            end
        end
    end

    task automatic put(int addr, int a, int b);
        @(negedge clk);
        wr_en = 1; wr_addr = AB'(addr); wr_y1 = DW'(a); wr_y2 = DW'(b);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pass(int sh, bit disturb);
        @(negedge clk);
        eta_shift = SW'(sh); start = 1;
        @(negedge clk);
        start = 0;
        while (busy) begin
            if (disturb) begin
                wr_en = 1; wr_addr = wr_addr + 1'b1; wr_y1 = 12'sd777; wr_y2 = -12'sd999;
                start = 1;
            end
            @(negedge clk);
        end
        wr_en = 0; start = 0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (cost_all != '0 || busy || done) begin
            errors++;
            $display("FAIL R1 reset actual=%h/%0b/%0b expected=0/0/0", cost_all, busy, done);
        end
        // R10 R4 R3 R7: mixed-sign frame, shift 2
        phase = "R4 R3 R7 R10";
        for (int i = 0; i < N; i++) put(i, (i * 137) % 900 - 450, 300 - i * 41);
        pass(2, 0);
        // R5: y1 zeros on even indices
        phase = "R5";
        for (int i = 0; i < N; i += 2) put(i, 0, 1500);
        pass(0, 0);
        // R6: negative b with odd shift
        phase = "R6";
        for (int i = 0; i < N; i++) put(i, (i % 3) - 1, -(i * 97) - 5);
        pass(3, 0);
        // R9: writes and starts during a pass are ignored
        phase = "R9";
        pass(1, 1);
        pass(1, 0);
        // R8 R11: saturate upward then downward
        phase = "R8 R11";
        for (int i = 0; i < N; i++) put(i, -2048, 2047);
        for (int r = 0; r < 5; r++) pass(0, 0);
        for (int i = 0; i < N; i++) put(i, 2047, 2047);
        for (int r = 0; r < 10; r++) pass(0, 0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule